// File: doc/BRIEF.md
# Boot-Overlay Memory Address Decoder

This block turns the 24-bit address bus of a 16-bit big-endian processor into active-low chip selects. It drives a pair of RAM chips (even and odd byte), a pair of ROM chips, one select for the I/O window and one for the expansion window. The expansion select is meant to be wired to the processor's bus-error input. Only one flat address space is decoded. Function-code lines are not inputs, and I/O shares the memory space.

A boot flag, active low, overlays ROM over the whole map. While the flag is held, every strobed access selects both ROM chips and nothing else. This lets the processor fetch its reset stack pointer and program counter from ROM at address zero, and those fetches are always full 16-bit reads. Once the flag is released, the normal map applies. RAM then sits at the bottom of memory, and the upper and lower data strobes pick the even and odd chip.

The decode is combinational. Its result is captured in one output register stage, so each select follows the bus inputs sampled at the previous rising clock edge. There is no data stream through the block, so every pin is a plain level signal.

Top module: `boot_overlay_decoder`

## Requirements
- R1: Outside boot mode, a strobed access to 0x000000..0x0FFFFF asserts the RAM chip selects and no other region. The boundary address 0x0FFFFF is still RAM.
- R2: Outside boot mode, a strobed access to 0x100000..0xF7FFFF asserts only the expansion select, whatever the data strobes are.
- R3: Outside boot mode, a strobed access to 0xF80000..0xFBFFFF asserts only the I/O select, whatever the data strobes are.
- R4: Outside boot mode, a strobed access to 0xFC0000..0xFFFFFF asserts the ROM chip selects and no other region.
- R5: Outside boot mode, the upper data strobe (data bits 15..8) enables the even chip of the RAM or ROM pair, and the lower data strobe enables the odd chip. A byte access asserts only the chip whose strobe is low, and with neither strobe low neither chip asserts.
- R6: While the boot flag is low, a strobed access at any address selects ROM. RAM, I/O and expansion selects stay high.
- R7: While the boot flag is low, the data strobes are ignored and both ROM chips are selected.
- R8: While the address strobe is high, every select output is high.
- R9: At most one of the four regions (RAM pair, ROM pair, I/O, expansion) has a select asserted at any time.
- R10: Select outputs change one clock after the inputs they reflect. While reset is low, all selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low; forces all selects inactive |
| bus_addr | input | 24 | Byte address bus |
| addr_strobe_n | input | 1 | Address strobe, active low |
| hi_strobe_n | input | 1 | Upper data strobe (bits 15..8), active low |
| lo_strobe_n | input | 1 | Lower data strobe (bits 7..0), active low |
| boot_n | input | 1 | Boot overlay flag, active low |
| ram_even_cs_n | output | 1 | Even (upper byte) RAM chip select, active low |
| ram_odd_cs_n | output | 1 | Odd (lower byte) RAM chip select, active low |
| rom_even_cs_n | output | 1 | Even (upper byte) ROM chip select, active low |
| rom_odd_cs_n | output | 1 | Odd (lower byte) ROM chip select, active low |
| io_cs_n | output | 1 | I/O window select, active low |
| exp_cs_n | output | 1 | Expansion window select, active low (bus-error source) |

## Verification
The map is probed at the first and last address of every region. Each pair of neighbours (0x0FFFFF/0x100000, 0xF7FFFF/0xF80000, 0xFBFFFF/0xFC0000) shows whether each comparison sits on the right side of its boundary. Word, upper-byte, lower-byte and no-strobe accesses to RAM and ROM show whether the two strobes are mapped to the correct chips and are not swapped. The same strobe patterns with the boot flag low, at RAM, I/O, expansion and ROM addresses, show whether the overlay overrides both the address and the lane decode. A check taken just before the clock edge tells the registered timing apart from a combinational path.

// File: rtl/bod_pkg.sv
package bod_pkg;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_RAM  = 3'd1,
    RGN_EXP  = 3'd2,
    RGN_IO   = 3'd3,
    RGN_ROM  = 3'd4
  } region_e;

  // active-high internal select vector
  typedef struct packed {
    logic ram_even;
    logic ram_odd;
    logic rom_even;
    logic rom_odd;
    logic io;
    logic exp;
  } sel_t;

  localparam int SEL_W = $bits(sel_t);

endpackage

// File: rtl/bod_region_decode.sv
module bod_region_decode
  import bod_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] RAM_LAST = 24'h0F_FFFF,
  parameter logic [ADDR_W-1:0] IO_BASE  = 24'hF8_0000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hFC_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe_n,
  input  logic              boot_n,
  output region_e           region
);

  always_comb begin
    region = RGN_NONE;
    if (!strobe_n) begin
      if (!boot_n)                region = RGN_ROM;
      else if (addr <= RAM_LAST)  region = RGN_RAM;
      else if (addr >= ROM_BASE)  region = RGN_ROM;
      else if (addr >= IO_BASE)   region = RGN_IO;
      else                        region = RGN_EXP;
    end
  end

endmodule

// File: rtl/bod_lane_select.sv
module bod_lane_select (
  input  logic hi_strobe_n,
  input  logic lo_strobe_n,
  input  logic boot_n,
  output logic even_en,
  output logic odd_en
);

  // overlay forces a full-width access on both chips
  always_comb begin
    even_en = !boot_n || !hi_strobe_n;
    odd_en  = !boot_n || !lo_strobe_n;
  end

endmodule

// File: rtl/bod_out_stage.sv
module bod_out_stage
  import bod_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  sel_t sel_d,
  output sel_t sel_n_q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_n_q <= '1;
        else        sel_n_q <= ~sel_d;
      end
    end else begin : g_comb
      always_comb sel_n_q = ~sel_d;
    end
  endgenerate

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bod_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] RAM_LAST = 24'h0F_FFFF,
  parameter logic [ADDR_W-1:0] IO_BASE  = 24'hF8_0000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hFC_0000,
  parameter bit                REG_OUT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              addr_strobe_n,
  input  logic              hi_strobe_n,
  input  logic              lo_strobe_n,
  input  logic              boot_n,
  output logic              ram_even_cs_n,
  output logic              ram_odd_cs_n,
  output logic              rom_even_cs_n,
  output logic              rom_odd_cs_n,
  output logic              io_cs_n,
  output logic              exp_cs_n
);

  region_e region;
  logic    even_en, odd_en;
  sel_t    sel_d, sel_n_q;

  bod_region_decode #(
    .ADDR_W  (ADDR_W),
    .RAM_LAST(RAM_LAST),
    .IO_BASE (IO_BASE),
    .ROM_BASE(ROM_BASE)
  ) u_region (
    .addr    (bus_addr),
    .strobe_n(addr_strobe_n),
    .boot_n  (boot_n),
    .region  (region)
  );

  bod_lane_select u_lanes (
    .hi_strobe_n(hi_strobe_n),
    .lo_strobe_n(lo_strobe_n),
    .boot_n     (boot_n),
    .even_en    (even_en),
    .odd_en     (odd_en)
  );

  always_comb begin
    sel_d          = '0;
    sel_d.ram_even = (region == RGN_RAM) && even_en;
    sel_d.ram_odd  = (region == RGN_RAM) && odd_en;
    sel_d.rom_even = (region == RGN_ROM) && even_en;
    sel_d.rom_odd  = (region == RGN_ROM) && odd_en;
    sel_d.io       = (region == RGN_IO);
    sel_d.exp      = (region == RGN_EXP);
  end

  bod_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_d  (sel_d),
    .sel_n_q(sel_n_q)
  );

  assign ram_even_cs_n = sel_n_q.ram_even;
  assign ram_odd_cs_n  = sel_n_q.ram_odd;
  assign rom_even_cs_n = sel_n_q.rom_even;
  assign rom_odd_cs_n  = sel_n_q.rom_odd;
  assign io_cs_n       = sel_n_q.io;
  assign exp_cs_n      = sel_n_q.exp;

endmodule

// File: rtl/boot_overlay_decoder_chk.sv
module boot_overlay_decoder_chk #(
  parameter int                ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] RAM_LAST = 24'h0F_FFFF,
  parameter logic [ADDR_W-1:0] IO_BASE  = 24'hF8_0000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hFC_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              addr_strobe_n,
  input logic              hi_strobe_n,
  input logic              lo_strobe_n,
  input logic              boot_n,
  input logic              ram_even_cs_n,
  input logic              ram_odd_cs_n,
  input logic              rom_even_cs_n,
  input logic              rom_odd_cs_n,
  input logic              io_cs_n,
  input logic              exp_cs_n
);

  logic norm;
  logic ram_any, rom_any;
  always_comb begin
    norm    = !addr_strobe_n && boot_n;
    ram_any = !ram_even_cs_n || !ram_odd_cs_n;
    rom_any = !rom_even_cs_n || !rom_odd_cs_n;
  end

  AST_RAM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && bus_addr <= RAM_LAST && !hi_strobe_n && !lo_strobe_n)
    |=> (!ram_even_cs_n && !ram_odd_cs_n && !rom_any && io_cs_n && exp_cs_n)); // R1

  AST_EXP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && bus_addr > RAM_LAST && bus_addr < IO_BASE)
    |=> (!exp_cs_n && io_cs_n && !ram_any && !rom_any)); // R2

  AST_IO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && bus_addr >= IO_BASE && bus_addr < ROM_BASE)
    |=> (!io_cs_n && exp_cs_n && !ram_any && !rom_any)); // R3

  AST_ROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && bus_addr >= ROM_BASE && !hi_strobe_n && !lo_strobe_n)
    |=> (!rom_even_cs_n && !rom_odd_cs_n && !ram_any && io_cs_n && exp_cs_n)); // R4

  AST_LOW_LANE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && hi_strobe_n && !lo_strobe_n)
    |=> (ram_even_cs_n && rom_even_cs_n)); // R5

  AST_HIGH_LANE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && !hi_strobe_n && lo_strobe_n)
    |=> (ram_odd_cs_n && rom_odd_cs_n)); // R5

  AST_BOOT_OVERLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_strobe_n && !boot_n)
    |=> (!rom_even_cs_n && !rom_odd_cs_n && !ram_any && io_cs_n && exp_cs_n)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe_n
    |=> (!ram_any && !rom_any && io_cs_n && exp_cs_n)); // R8

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_any, rom_any, !io_cs_n, !exp_cs_n}) <= 1); // R9

endmodule

bind boot_overlay_decoder boot_overlay_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .RAM_LAST(RAM_LAST),
  .IO_BASE (IO_BASE),
  .ROM_BASE(ROM_BASE)
) u_chk (.*);

// File: tb/boot_overlay_decoder_tb_top.sv
module boot_overlay_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        addr_strobe_n = 1'b1;
  logic        hi_strobe_n = 1'b1;
  logic        lo_strobe_n = 1'b1;
  logic        boot_n = 1'b1;
  logic        ram_even_cs_n, ram_odd_cs_n, rom_even_cs_n, rom_odd_cs_n, io_cs_n, exp_cs_n;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10ns clk = ~clk;

  boot_overlay_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .addr_strobe_n(addr_strobe_n), .hi_strobe_n(hi_strobe_n),
    .lo_strobe_n(lo_strobe_n), .boot_n(boot_n),
    .ram_even_cs_n(ram_even_cs_n), .ram_odd_cs_n(ram_odd_cs_n),
    .rom_even_cs_n(rom_even_cs_n), .rom_odd_cs_n(rom_odd_cs_n),
    .io_cs_n(io_cs_n), .exp_cs_n(exp_cs_n)
  );

  // observed order: ram_even ram_odd rom_even rom_odd io exp (active low)
  localparam logic [5:0] IDLE     = 6'b111111;
  localparam logic [5:0] RAM_W    = 6'b001111;
  localparam logic [5:0] RAM_HI   = 6'b011111;
  localparam logic [5:0] RAM_LO   = 6'b101111;
  localparam logic [5:0] ROM_W    = 6'b110011;
  localparam logic [5:0] ROM_HI   = 6'b110111;
  localparam logic [5:0] ROM_LO   = 6'b111011;
  localparam logic [5:0] IO_SEL   = 6'b111101;
  localparam logic [5:0] EXP_SEL  = 6'b111110;

  function automatic logic [5:0] outs();
    return {ram_even_cs_n, ram_odd_cs_n, rom_even_cs_n, rom_odd_cs_n, io_cs_n, exp_cs_n};
  endfunction

  task automatic check(string req, logic [5:0] expv);
    n_run++;
    if (outs() !== expv) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, outs(), expv);
    end
  endtask

  // drive on falling edge, result visible after the next rising edge
  task automatic access(logic [23:0] a, logic as_n, logic uds, logic lds, logic bt,
                        string req, logic [5:0] expv);
    @(negedge clk);
    bus_addr = a; addr_strobe_n = as_n; hi_strobe_n = uds; lo_strobe_n = lds; boot_n = bt;
    @(negedge clk);
    check(req, expv);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    bus_addr = 24'h000010; addr_strobe_n = 1'b0; hi_strobe_n = 1'b0; lo_strobe_n = 1'b0;
    boot_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset", IDLE);
    addr_strobe_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset idle", IDLE);
  endtask

  task automatic t_ram();
    access(24'h000000, 0, 0, 0, 1, "R1 ram base", RAM_W);
    access(24'h0FFFFF, 0, 0, 0, 1, "R1 ram last", RAM_W);
    access(24'h054320, 0, 0, 0, 1, "R1 ram mid", RAM_W);
  endtask

  task automatic t_exp();
    access(24'h100000, 0, 0, 0, 1, "R2 exp first", EXP_SEL);
    access(24'hF7FFFF, 0, 0, 0, 1, "R2 exp last", EXP_SEL);
    access(24'h800000, 0, 1, 1, 1, "R2 exp no strobes", EXP_SEL);
  endtask

  task automatic t_io();
    access(24'hF80000, 0, 0, 0, 1, "R3 io first", IO_SEL);
    access(24'hFBFFFF, 0, 0, 1, 1, "R3 io last byte", IO_SEL);
  endtask

  task automatic t_rom();
    access(24'hFC0000, 0, 0, 0, 1, "R4 rom first", ROM_W);
    access(24'hFFFFFF, 0, 0, 0, 1, "R4 rom last", ROM_W);
  endtask

  task automatic t_lanes();
    access(24'h000101, 0, 1, 0, 1, "R5 ram low byte", RAM_LO);
    access(24'h000100, 0, 0, 1, 1, "R5 ram high byte", RAM_HI);
    access(24'hFD0000, 0, 0, 1, 1, "R5 rom high byte", ROM_HI);
    access(24'hFD0001, 0, 1, 0, 1, "R5 rom low byte", ROM_LO);
    access(24'h000200, 0, 1, 1, 1, "R5 ram no strobes", IDLE);
  endtask

  task automatic t_boot();
    access(24'h000000, 0, 0, 0, 0, "R6 boot at zero", ROM_W);
    access(24'h000004, 0, 0, 0, 0, "R6 boot ram addr", ROM_W);
    access(24'hF90000, 0, 0, 0, 0, "R6 boot io addr", ROM_W);
    access(24'h300000, 0, 0, 0, 0, "R6 boot exp addr", ROM_W);
    access(24'h000002, 0, 1, 1, 0, "R7 boot no strobes", ROM_W);
    access(24'h000003, 0, 1, 0, 0, "R7 boot low strobe only", ROM_W);
    access(24'h000000, 1, 0, 0, 0, "R8 boot strobe idle", IDLE);
  endtask

  task automatic t_idle();
    access(24'h000000, 1, 0, 0, 1, "R8 idle ram", IDLE);
    access(24'hF80000, 1, 0, 0, 1, "R8 idle io", IDLE);
    access(24'hFC0000, 1, 0, 0, 1, "R8 idle rom", IDLE);
  endtask

  task automatic t_latency();
    @(negedge clk);
    bus_addr = 24'h000040; addr_strobe_n = 1'b0; hi_strobe_n = 1'b0; lo_strobe_n = 1'b0;
    boot_n = 1'b1;
    #5ns check("R10 before edge", IDLE);
    @(negedge clk);
    check("R10 after edge", RAM_W);
    addr_strobe_n = 1'b1;
    #5ns check("R10 hold before edge", RAM_W);
    @(negedge clk);
    check("R10 release after edge", IDLE);
  endtask

  task automatic t_one_region();
    access(24'h0FFFFF, 0, 0, 0, 1, "R9 ram side", RAM_W);
    access(24'h100000, 0, 0, 0, 1, "R9 exp side", EXP_SEL);
    access(24'hFBFFFF, 0, 0, 0, 1, "R9 io side", IO_SEL);
    access(24'hFC0000, 0, 0, 0, 1, "R9 rom side", ROM_W);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ram();
    t_exp();
    t_io();
    t_rom();
    t_lanes();
    t_boot();
    t_idle();
    t_latency();
    t_one_region();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule